// File: doc/BRIEF.md
# Preamble-Synced Byte Framer

This block sits behind a bit-timing recovery stage and turns a stream of recovered bits into bytes. Each recovered bit arrives as a one-cycle strobe together with its value. While hunting, the framer watches for a run of ones closed by a single zero. That pattern marks the start of a packet, and the closing zero is reused as the start bit of the first byte frame.

From then on the framer cuts the stream into frames of eleven bits with no gaps between them. Each frame holds a start bit (0), eight data bits with the least significant bit first, an odd-parity bit and a stop bit (1). Every finished frame produces a single-cycle byte strobe. The byte comes with three error flags in the same cycle. A malformed frame is still delivered, and the flags tell the consumer what was wrong with it. An abort input, normally driven by the timing stage when it loses lock, sends the framer back to hunting and discards any partial frame.

Top module: `byte_framer`

## Requirements
- R1: After a synchronous active-high reset, byte_valid, byte_data, all three error flags and preamble_hit are 0, and the framer is hunting.
- R2: While hunting, four accepted bits of 1 followed directly by an accepted 0 give a one-cycle preamble_hit pulse in the cycle after that 0 is accepted. Shorter runs of ones give no pulse.
- R3: The closing 0 of the preamble counts as the start bit of the first frame, so that frame completes after ten more accepted bits.
- R4: After the eleventh accepted bit of a frame, byte_valid is high for exactly one cycle. byte_data then holds frame bits 1..8, with bit 1 as byte_data[0].
- R5: parity_err is 1 when frame bit 9 differs from 1 XOR (XOR of the eight data bits), so the data plus parity must hold an odd number of ones.
- R6: start_err is 1 when frame bit 0 is 1, and stop_err is 1 when frame bit 10 is 0. A flagged byte is still delivered. All flags are 0 in any cycle without byte_valid.
- R7: The accepted bit after a frame's eleventh bit is bit 0 of the next frame, and no preamble is needed in between.
- R8: While framing, a 1,1,1,1,0 run inside the data gives no preamble_hit and does not change frame alignment.
- R9: Abort returns the framer to hunting, discards the partial frame and clears the preamble history. A bit presented in the same cycle as abort is ignored.
- R10: Cycles with bit_valid low change neither the framer's position nor its history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | One recovered bit is presented this cycle |
| bit_val | input | 1 | Value of the presented bit |
| abort | input | 1 | Return to hunting and drop the partial frame |
| byte_valid | output | 1 | One-cycle strobe for a completed frame |
| byte_data | output | DATA_W | Data bits of the completed frame, LSB first on the line |
| start_err | output | 1 | Start bit of the frame was 1 |
| parity_err | output | 1 | Odd-parity check failed |
| stop_err | output | 1 | Stop bit of the frame was 0 |
| preamble_hit | output | 1 | One-cycle pulse when the sync pattern is found |

## Verification
The bench builds the framer with its defaults: eight data bits and a preamble of four ones. This makes the all-zero and all-one bytes reachable, where the parity bit is 1 in both cases, and it allows a data byte of 0x0F to embed the sync pattern inside a frame. With these widths, back-to-back frames, strobes separated by idle cycles, each error flag alone and all three together can be reached in a few hundred cycles. So can aborts that land mid-frame, mid-preamble and in the same cycle as the closing zero.

// File: rtl/framer_pkg.sv
package framer_pkg;

    typedef enum logic {
        ST_HUNT  = 1'b0,
        ST_FRAME = 1'b1
    } fr_state_e;

    typedef struct packed {
        logic start_bad;
        logic parity_bad;
        logic stop_bad;
    } fr_flags_t;

    // Parity bit a well-formed frame carries: 1 XOR all data bits.
    function automatic logic odd_fill(input logic [63:0] v, input int w);
        logic acc;
        acc = 1'b1;
        for (int i = 0; i < 64; i++) begin
            if (i < w) acc = acc ^ v[i];
        end
        return acc;
    endfunction

endpackage

// File: rtl/fr_preamble_det.sv
module fr_preamble_det #(
    parameter int ONES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic shift_en,
    input  logic clear,
    input  logic bit_in,
    output logic hit
);
    localparam int PW = ONES + 1;
    localparam logic [PW-1:0] SYNC_PAT = {{ONES{1'b1}}, 1'b0};

    logic [ONES-1:0] hist;
    logic [PW-1:0]   window;

    assign window = {hist, bit_in};
    assign hit    = shift_en && (window == SYNC_PAT);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            hist <= '0;
        end else if (shift_en) begin
            hist <= window[ONES-1:0];
        end
    end

    // R9
    hist_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        (clear && !shift_en) |=> !hit);

endmodule

// File: rtl/fr_assembler.sv
module fr_assembler #(
    parameter int DATA_W = 8,
    parameter int ONES   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              abort,
    input  logic              bit_valid,
    input  logic              bit_in,
    output logic              frame_done,
    output logic [DATA_W+2:0] frame_bits,
    output logic              pre_pulse
);
    localparam int FW = DATA_W + 3;
    localparam int CW = $clog2(FW);
    localparam logic [CW-1:0] LAST = CW'(FW - 1);

    framer_pkg::fr_state_e state;
    logic [CW-1:0] cnt;
    logic [FW-1:0] buffer;
    logic          take;
    logic          hit;
    logic          hunt_shift;

    assign take       = bit_valid && !abort;
    assign hunt_shift = take && (state == framer_pkg::ST_HUNT);

    fr_preamble_det #(.ONES(ONES)) u_det (
        .clk      (clk),
        .rst      (rst),
        .shift_en (hunt_shift),
        .clear    (abort || hit),
        .bit_in   (bit_in),
        .hit      (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= framer_pkg::ST_HUNT;
            cnt        <= '0;
            buffer     <= '0;
            frame_done <= 1'b0;
            frame_bits <= '0;
            pre_pulse  <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            pre_pulse  <= 1'b0;
            if (abort) begin
                state  <= framer_pkg::ST_HUNT;
                cnt    <= '0;
                buffer <= '0;
            end else if (take) begin
                if (state == framer_pkg::ST_HUNT) begin
                    if (hit) begin
                        state     <= framer_pkg::ST_FRAME;
                        buffer    <= '0;
                        cnt       <= CW'(1);
                        pre_pulse <= 1'b1;
                    end
                end else begin
                    buffer[cnt] <= bit_in;
                    if (cnt == LAST) begin
                        frame_done <= 1'b1;
                        frame_bits <= {bit_in, buffer[FW-2:0]};
                        cnt        <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    end

    // R10
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!bit_valid && !abort) |=> ($stable(cnt) && $stable(state)));

    // R7
    frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (cnt == '0 && state == framer_pkg::ST_FRAME));

    // R3
    start_reused_chk: assert property (@(posedge clk) disable iff (rst)
        pre_pulse |-> (cnt == CW'(1)));

endmodule

// File: rtl/fr_decode.sv
module fr_decode #(
    parameter int DATA_W = 8
) (
    input  logic                  frame_done,
    input  logic [DATA_W+2:0]     frame_bits,
    output logic [DATA_W-1:0]     data,
    output framer_pkg::fr_flags_t flags
);
    localparam int FW = DATA_W + 3;

    logic [DATA_W-1:0] raw;
    assign raw = frame_bits[DATA_W:1];

    always_comb begin
        data  = '0;
        flags = '0;
        if (frame_done) begin
            data             = raw;
            flags.start_bad  = frame_bits[0];
            flags.parity_bad = frame_bits[DATA_W+1] != framer_pkg::odd_fill(64'(raw), DATA_W);
            flags.stop_bad   = !frame_bits[FW-1];
        end
    end

endmodule

// File: rtl/byte_framer.sv
module byte_framer #(
    parameter int DATA_W = 8,
    parameter int ONES   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_valid,
    input  logic              bit_val,
    input  logic              abort,
    output logic              byte_valid,
    output logic [DATA_W-1:0] byte_data,
    output logic              start_err,
    output logic              parity_err,
    output logic              stop_err,
    output logic              preamble_hit
);
    logic                  done;
    logic [DATA_W+2:0]     fbits;
    framer_pkg::fr_flags_t flags;

    fr_assembler #(.DATA_W(DATA_W), .ONES(ONES)) u_asm (
        .clk        (clk),
        .rst        (rst),
        .abort      (abort),
        .bit_valid  (bit_valid),
        .bit_in     (bit_val),
        .frame_done (done),
        .frame_bits (fbits),
        .pre_pulse  (preamble_hit)
    );

    fr_decode #(.DATA_W(DATA_W)) u_dec (
        .frame_done (done),
        .frame_bits (fbits),
        .data       (byte_data),
        .flags      (flags)
    );

    assign byte_valid = done;
    assign start_err  = flags.start_bad;
    assign parity_err = flags.parity_bad;
    assign stop_err   = flags.stop_bad;

    // R4
    byte_one_shot_chk: assert property (@(posedge clk) disable iff (rst)
        byte_valid |=> !byte_valid);

    // R2
    sync_one_shot_chk: assert property (@(posedge clk) disable iff (rst)
        preamble_hit |=> !preamble_hit);

    // R6
    flags_gated_chk: assert property (@(posedge clk) disable iff (rst)
        !byte_valid |-> !(start_err || parity_err || stop_err));

    // R9
    abort_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!byte_valid && !preamble_hit));

endmodule

// File: tb/byte_framer_tb.sv
module byte_framer_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [7:0] d;
        logic       s;
        logic       p;
        logic       t;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_valid = 1'b0;
    logic bit_val = 1'b0;
    logic abort = 1'b0;
    logic byte_valid, start_err, parity_err, stop_err, preamble_hit;
    logic [7:0] byte_data;

    exp_t q[$];
    int n_checks = 0;
    int n_fail = 0;
    int seen_pre = 0;
    int exp_pre = 0;
    int cyc = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_framer u_dut (
        .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_val(bit_val),
        .abort(abort), .byte_valid(byte_valid), .byte_data(byte_data),
        .start_err(start_err), .parity_err(parity_err), .stop_err(stop_err),
        .preamble_hit(preamble_hit)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Monitor: compare each produced byte with the head of the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (preamble_hit) seen_pre++;
            if (byte_valid) begin
                if (q.size() == 0) begin
                    chk(0, "R4", "unexpected byte", int'(byte_data), 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(byte_data == e.d, "R4", "byte data", int'(byte_data), int'(e.d));
                    chk(parity_err == e.p, "R5", "parity flag", int'(parity_err), int'(e.p));
                    chk(start_err == e.s, "R6", "start flag", int'(start_err), int'(e.s));
                    chk(stop_err == e.t, "R6", "stop flag", int'(stop_err), int'(e.t));
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 100000 && !finished) begin
            n_fail++;
            $display("FAIL R4 watchdog actual=timeout expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, input int gap_n);
        bit_valid = 1'b1;
        bit_val   = b;
        @(negedge clk);
        bit_valid = 1'b0;
        if (gap_n > 0) idle(gap_n);
    endtask

    task automatic send_preamble();
        for (int i = 0; i < 4; i++) send_bit(1'b1, 0);
        send_bit(1'b0, 0);
    endtask

    task automatic send_frame(input logic [7:0] d, input bit first, input bit bad_s,
                              input bit bad_p, input bit bad_t, input int gap_n);
        exp_t e;
        logic par;
        e.d = d; e.s = bad_s; e.p = bad_p; e.t = bad_t;
        q.push_back(e);
        if (!first) send_bit(bad_s, gap_n);
        for (int i = 0; i < 8; i++) send_bit(d[i], gap_n);
        par = ~(^d) ^ bad_p;
        send_bit(par, gap_n);
        send_bit(!bad_t, gap_n);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(byte_valid == 0 && preamble_hit == 0, "R1", "strobes after reset",
            int'({byte_valid, preamble_hit}), 0);
        chk(byte_data == 0 && {start_err, parity_err, stop_err} == 0, "R1",
            "data/flags after reset", int'(byte_data), 0);

        // R2: three ones then zero is not a preamble
        send_bit(1, 0); send_bit(1, 0); send_bit(1, 0); send_bit(0, 0);
        idle(2);
        chk(seen_pre == 0, "R2", "short run sync count", seen_pre, 0);

        // R2 + R3: preamble, first frame needs ten more bits
        send_preamble(); exp_pre++;
        send_frame(8'hA5, 1, 0, 0, 0, 0);
        // R7: back-to-back frames
        send_frame(8'h3C, 0, 0, 0, 0, 0);
        // R5: parity corners
        send_frame(8'h00, 0, 0, 0, 0, 0);
        send_frame(8'hFF, 0, 0, 0, 0, 0);
        send_frame(8'h5A, 0, 0, 1, 0, 0);
        // R6: start and stop violations, still delivered
        send_frame(8'h81, 0, 1, 0, 0, 0);
        send_frame(8'h7E, 0, 0, 0, 1, 0);
        send_frame(8'hC3, 0, 1, 1, 1, 0);
        // R8: sync pattern inside data
        send_frame(8'h0F, 0, 0, 0, 0, 0);
        send_frame(8'h1E, 0, 0, 0, 0, 0);
        // R10: gaps between strobes
        send_frame(8'h69, 0, 0, 0, 0, 3);
        idle(2);
        chk(seen_pre == exp_pre, "R8", "sync count while framing", seen_pre, exp_pre);
        chk(q.size() == 0, "R7", "pending bytes", q.size(), 0);

        // R9: abort mid-frame discards the partial byte
        send_bit(0, 0); send_bit(1, 0); send_bit(1, 0); send_bit(0, 0);
        abort = 1'b1; @(negedge clk); abort = 1'b0;
        for (int i = 0; i < 7; i++) send_bit(1, 0);
        idle(2);
        chk(seen_pre == exp_pre, "R9", "no sync after abort ones", seen_pre, exp_pre);
        abort = 1'b1; @(negedge clk); abort = 1'b0;
        // R9: abort clears the history of ones
        send_bit(1, 0); send_bit(1, 0); send_bit(1, 0); send_bit(1, 0);
        abort = 1'b1; @(negedge clk); abort = 1'b0;
        send_bit(0, 0);
        idle(2);
        chk(seen_pre == exp_pre, "R9", "history cleared", seen_pre, exp_pre);
        // R9: closing zero in the same cycle as abort is ignored
        send_bit(1, 0); send_bit(1, 0); send_bit(1, 0); send_bit(1, 0);
        abort = 1'b1; bit_valid = 1'b1; bit_val = 1'b0;
        @(negedge clk);
        abort = 1'b0; bit_valid = 1'b0;
        idle(2);
        chk(seen_pre == exp_pre, "R9", "same-cycle abort", seen_pre, exp_pre);
        // recovery after abort
        send_preamble(); exp_pre++;
        send_frame(8'h96, 1, 0, 0, 0, 0);
        idle(3);
        chk(seen_pre == exp_pre, "R2", "final sync count", seen_pre, exp_pre);
        chk(q.size() == 0, "R9", "bytes after recovery", q.size(), 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule